// File: doc/BRIEF.md
# Transmit FIFO DMA Controller

This block feeds several transmit FIFOs from memory. Each channel has an enable, an interrupt enable, a byte count and a memory address. A channel asks for service when it is enabled, its FIFO is empty and it still has bytes left to move. The controller then raises a bus request. After the grant it serves the waiting channels in fixed priority order, with channel 0 highest. Each byte takes two cycles: a memory read with a one-cycle return, then a strobe into the chosen FIFO.

A burst runs until the FIFO reports full or the channel's count reaches zero. A higher-priority channel that starts waiting during a burst does not interrupt it. By default the bus stays held from one channel to the next until no channel is waiting. A mode input instead gives the bus back after every burst and asks for it again. When a channel's count reaches zero through a transfer, its interrupt is latched if enabled for it. The interrupt stays set until a write-one-to-clear pulse removes it.

Top module: `txdma_ctrl`

## Requirements
- R1: After reset, bus_req, mem_rd, every fifo_we bit and every irq bit are 0.
- R2: A channel is waiting exactly when ch_en, fifo_empty are 1 and its count is nonzero; no other condition, such as the state of the serial transmitter, gates it. With no channel in service and the bus not owned, a waiting channel raises bus_req on the following cycle.
- R3: Once a channel is selected, each byte is one cycle with mem_rd=1 and mem_addr set to its address, then one cycle with fifo_we set for that channel and fifo_wdata equal to mem_rdata. Before each read the controller checks fifo_full and the count; if either ends the burst, no read is issued.
- R4: The next channel is chosen only when no burst is in progress, and it is the lowest-numbered waiting channel.
- R5: A burst is not interrupted when a higher-priority channel starts waiting during it.
- R6: With rel_each=0, bus_req stays high from one burst to the next and drops only when no channel is waiting.
- R7: With rel_each=1, bus_req goes low for at least one cycle after every burst and is raised again for the next waiting channel.
- R8: A cfg_we pulse loads cfg_addr and cfg_cnt into the channel named by cfg_sel. Each byte moved adds one to that channel's address and subtracts one from its count.
- R9: When a transfer brings a channel's count from 1 to 0, its irq bit is set if irq_en for that channel is 1, and stays 0 otherwise.
- R10: A set irq bit stays set until a cycle with the matching irq_clr bit at 1. It clears on the following edge, and a new terminal count in that same cycle wins.
- R11: After a request, bus_req is not withdrawn until bus_gnt has been seen, and memory reads happen only while both bus_req and bus_gnt are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_en | input | NCH | Per-channel DMA enable |
| irq_en | input | NCH | Per-channel interrupt enable |
| rel_each | input | 1 | 1 releases the bus after every burst |
| cfg_we | input | 1 | Load strobe for one channel's address and count |
| cfg_sel | input | SW | Channel index for the load |
| cfg_addr | input | AW | Start address to load |
| cfg_cnt | input | CW | Byte count to load |
| irq_clr | input | NCH | Write-one-to-clear for pending interrupts |
| fifo_empty | input | NCH | Per-channel FIFO empty flag |
| fifo_full | input | NCH | Per-channel FIFO full flag |
| bus_req | output | 1 | System bus request |
| bus_gnt | input | 1 | System bus grant |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | AW | Memory read address |
| mem_rdata | input | DW | Read data, valid the cycle after mem_rd |
| fifo_we | output | NCH | Per-channel FIFO write strobe |
| fifo_wdata | output | DW | Byte written to the FIFO |
| irq | output | NCH | Pending interrupt per channel |

## Verification
Most internal faults show up at the ports within a few cycles. A bad count or address appears at mem_addr on the next read, or as one byte too many or too few before the burst ends. A wrong selection appears at the first fifo_we of the burst. A wrong hold or release decision shows in bus_req within one cycle of the burst's last read check. A behavioural reference model predicts every output on every clock, so any divergence is caught in the cycle it occurs. End-of-scenario checks on byte totals, interrupt bits and bus request edges tie the results back to each requirement.

// File: rtl/txdma_ctrl.sv
module txdma_ctrl #(
  parameter int NCH = 4,
  parameter int AW  = 32,
  parameter int CW  = 16,
  parameter int DW  = 8,
  localparam int SW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] ch_en,
  input  logic [NCH-1:0] irq_en,
  input  logic           rel_each,
  input  logic           cfg_we,
  input  logic [SW-1:0]  cfg_sel,
  input  logic [AW-1:0]  cfg_addr,
  input  logic [CW-1:0]  cfg_cnt,
  input  logic [NCH-1:0] irq_clr,
  input  logic [NCH-1:0] fifo_empty,
  input  logic [NCH-1:0] fifo_full,
  output logic           bus_req,
  input  logic           bus_gnt,
  output logic           mem_rd,
  output logic [AW-1:0]  mem_addr,
  input  logic [DW-1:0]  mem_rdata,
  output logic [NCH-1:0] fifo_we,
  output logic [DW-1:0]  fifo_wdata,
  output logic [NCH-1:0] irq
);

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_PICK, S_RD, S_WR} st_t;

  st_t            st;
  logic [SW-1:0]  cur, sel;
  logic [AW-1:0]  addr_q [NCH];
  logic [CW-1:0]  cnt_q  [NCH];
  logic [NCH-1:0] live, pend, irq_q;
  logic           stop;

  assign pend       = ch_en & fifo_empty & live;
  assign stop       = fifo_full[cur] || (cnt_q[cur] == '0);
  assign bus_req    = (st != S_IDLE);
  assign mem_rd     = (st == S_RD) && !stop;
  assign mem_addr   = addr_q[cur];
  assign fifo_wdata = mem_rdata;
  assign irq        = irq_q;

  always_comb begin
    sel = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (pend[i]) sel = SW'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cur <= '0;
    end else begin
      case (st)
        S_IDLE: if (|pend) st <= S_REQ;
        S_REQ:  if (bus_gnt) st <= S_PICK;
        S_PICK: if (|pend) begin
                  st  <= S_RD;
                  cur <= sel;
                end else st <= S_IDLE;
        S_RD:   if (stop) st <= rel_each ? S_IDLE : S_PICK;
                else st <= S_WR;
        S_WR:   st <= S_RD;
        default: st <= S_IDLE;
      endcase
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic hit;
    assign hit        = (st == S_WR) && (cur == SW'(i));
    assign fifo_we[i] = hit;
    assign live[i]    = (cnt_q[i] != '0);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        addr_q[i] <= '0;
        cnt_q[i]  <= '0;
        irq_q[i]  <= 1'b0;
      end else begin
        if (cfg_we && cfg_sel == SW'(i)) begin
          addr_q[i] <= cfg_addr;
          cnt_q[i]  <= cfg_cnt;
        end else if (hit) begin
          addr_q[i] <= addr_q[i] + 1'b1;
          cnt_q[i]  <= cnt_q[i] - 1'b1;
        end
        if (hit && cnt_q[i] == CW'(1) && irq_en[i]) irq_q[i] <= 1'b1;
        else if (irq_clr[i])                        irq_q[i] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/txdma_ctrl_chk.sv
module txdma_ctrl_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_req,
  input logic           bus_gnt,
  input logic           mem_rd,
  input logic [NCH-1:0] fifo_we,
  input logic [NCH-1:0] irq,
  input logic [NCH-1:0] irq_clr
);

  p_we_after_rd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|fifo_we) |-> $past(mem_rd));

  p_rd_then_we_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> (|fifo_we));

  p_one_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fifo_we));

  p_rd_owns_bus_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (bus_req && bus_gnt));

  p_drop_after_gnt_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_req) |-> $past(bus_gnt));

  for (genvar i = 0; i < NCH; i++) begin : g_irq
    p_irq_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq[i] && !irq_clr[i]) |=> irq[i]);
  end

endmodule

bind txdma_ctrl txdma_ctrl_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_gnt(bus_gnt),
  .mem_rd(mem_rd), .fifo_we(fifo_we), .irq(irq), .irq_clr(irq_clr)
);

// File: tb/sim_txdma_ctrl.sv
`timescale 1ns/100ps
module sim_txdma_ctrl;
  localparam int NCH = 4, AW = 32, CW = 16, DW = 8, SW = 2, FD = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic           rst_n;
  logic [NCH-1:0] ch_en, irq_en, irq_clr, fifo_empty, fifo_full;
  logic           rel_each, cfg_we, bus_gnt;
  logic [SW-1:0]  cfg_sel;
  logic [AW-1:0]  cfg_addr;
  logic [CW-1:0]  cfg_cnt;
  logic [DW-1:0]  mem_rdata;
  logic           bus_req, mem_rd;
  logic [AW-1:0]  mem_addr;
  logic [NCH-1:0] fifo_we, irq;
  logic [DW-1:0]  fifo_wdata;

  txdma_ctrl #(.NCH(NCH), .AW(AW), .CW(CW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .irq_en(irq_en), .rel_each(rel_each),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_addr(cfg_addr), .cfg_cnt(cfg_cnt),
    .irq_clr(irq_clr), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .fifo_we(fifo_we), .fifo_wdata(fifo_wdata), .irq(irq));

  int total = 0, bad = 0, cyc = 0;

  // stimulus variables
  logic           v_rst = 1'b0, v_rel = 1'b0, v_cfg = 1'b0;
  logic [NCH-1:0] v_en = '0, v_ien = '0, v_clr = '0, v_drain = '0;
  int             v_sel = 0, v_addr = 0, v_cnt = 0;

  // environment and reference model state
  int  occ [NCH];
  bit  gnt_v = 0;
  int  gwait = 0;
  logic [DW-1:0] rd_v = '0;
  int  ph = 0, mcur = 0;
  int  maddr [NCH], mcnt [NCH], dut_w [NCH];
  bit  mirq [NCH];
  int  req_rises = 0, first_ch = -1;
  bit  prev_req = 0;

  function automatic logic [DW-1:0] memf(int a);
    return DW'(a) ^ DW'(a >> 8) ^ 8'h3C;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h cycle=%0d", tag, act, exp, cyc);
    end
  endtask

  task automatic step();
    bit e_req, e_rd, any;
    int lo;
    logic [NCH-1:0] e_we, e_irq, p;
    @(negedge clk);
    cyc++;
    rst_n = v_rst; ch_en = v_en; irq_en = v_ien; rel_each = v_rel; irq_clr = v_clr;
    cfg_we = v_cfg; cfg_sel = SW'(v_sel); cfg_addr = AW'(v_addr); cfg_cnt = CW'(v_cnt);
    for (int i = 0; i < NCH; i++) begin
      fifo_empty[i] = (occ[i] == 0);
      fifo_full[i]  = (occ[i] == FD);
    end
    bus_gnt = gnt_v; mem_rdata = rd_v;
    #1;
    e_req = v_rst && ph != 0;
    e_rd  = v_rst && ph == 3 && !fifo_full[mcur] && mcnt[mcur] != 0;
    e_we  = '0;
    if (v_rst && ph == 4) e_we[mcur] = 1'b1;
    for (int i = 0; i < NCH; i++) e_irq[i] = mirq[i];
    chk(bus_req == e_req, "R6 bus_req", bus_req, e_req);
    chk(mem_rd == e_rd, "R3 mem_rd", mem_rd, e_rd);
    if (e_rd) chk(mem_addr == AW'(maddr[mcur]), "R8 mem_addr", mem_addr, maddr[mcur]);
    chk(fifo_we == e_we, "R5 fifo_we", fifo_we, e_we);
    if (e_we != 0) chk(fifo_wdata == memf(maddr[mcur]), "R3 fifo_wdata", fifo_wdata, memf(maddr[mcur]));
    chk(irq == e_irq, "R9 irq", irq, e_irq);
    for (int i = 0; i < NCH; i++) if (fifo_we[i]) dut_w[i]++;
    if (bus_req && !prev_req) req_rises++;
    prev_req = bus_req;
    if (fifo_we != 0 && first_ch < 0)
      for (int i = NCH - 1; i >= 0; i--) if (fifo_we[i]) first_ch = i;

    // advance model
    if (!v_rst) begin
      ph = 0; mcur = 0;
      for (int i = 0; i < NCH; i++) begin maddr[i] = 0; mcnt[i] = 0; mirq[i] = 0; end
    end else begin
      for (int i = 0; i < NCH; i++) p[i] = ch_en[i] && fifo_empty[i] && mcnt[i] != 0;
      any = (p != 0);
      lo = 0;
      for (int i = NCH - 1; i >= 0; i--) if (p[i]) lo = i;
      case (ph)
        0: if (any) ph = 1;
        1: if (gnt_v) ph = 2;
        2: if (any) begin ph = 3; mcur = lo; end else ph = 0;
        3: if (!e_rd) ph = v_rel ? 0 : 2; else ph = 4;
        default: begin
          if (mcnt[mcur] == 1 && v_ien[mcur]) mirq[mcur] = 1;
          else if (v_clr[mcur]) mirq[mcur] = 0;
          maddr[mcur]++; mcnt[mcur]--;
          ph = 3;
        end
      endcase
      for (int i = 0; i < NCH; i++)
        if (v_clr[i] && !(e_we[i] && e_irq[i] == 0 && mirq[i])) begin
          if (!(e_we[i])) mirq[i] = 0;
        end
      if (v_cfg) begin maddr[v_sel] = v_addr; mcnt[v_sel] = v_cnt; end
    end
    // environment
    for (int i = 0; i < NCH; i++) begin
      if (e_we[i]) occ[i]++;
      if (v_drain[i] && occ[i] > 0 && cyc % 3 == 0) occ[i]--;
    end
    if (e_rd) rd_v = memf(maddr[mcur] - (ph == 4 ? 0 : 0));
    if (e_req) gwait++; else gwait = 0;
    gnt_v = e_req && gwait >= 2;
    v_cfg = 0; v_clr = '0;
  endtask

  task automatic run(int n);
    for (int k = 0; k < n; k++) step();
  endtask

  task automatic load(int ch, int a, int n);
    v_cfg = 1; v_sel = ch; v_addr = a; v_cnt = n;
    step();
  endtask

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog act=%0d exp=0", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NCH; i++) begin occ[i] = 0; dut_w[i] = 0; maddr[i] = 0; mcnt[i] = 0; mirq[i] = 0; end
    run(3);
    chk(bus_req == 0 && mem_rd == 0 && fifo_we == 0 && irq == 0, "R1 reset outputs",
        {bus_req, mem_rd, fifo_we, irq}, 0);
    v_rst = 1;
    v_ien = 4'b0111;
    run(2);

    // A: two channels, bus held between bursts
    load(1, 'h100, 6);
    load(2, 'h2F0, 3);
    req_rises = 0;
    v_en = 4'b0110;
    run(60);
    chk(first_ch == 1, "R4 first served channel", first_ch, 1);
    chk(dut_w[1] == 4, "R3 burst stops at full", dut_w[1], 4);
    chk(dut_w[2] == 3, "R3 burst stops at count", dut_w[2], 3);
    chk(req_rises == 1, "R6 single bus tenure", req_rises, 1);
    chk(irq == 4'b0100, "R9 irq on terminal count", irq, 4'b0100);

    // B: ch1 drains, refills remainder; ch2 irq stays pending
    v_drain = 4'b0010;
    run(100);
    chk(dut_w[1] == 6, "R8 ch1 total bytes", dut_w[1], 6);
    chk(irq == 4'b0110, "R10 irq held without clear", irq, 4'b0110);
    v_clr = 4'b0100;
    step();
    run(2);
    chk(irq == 4'b0010, "R10 w1c clears only ch2", irq, 4'b0010);

    // C: release per burst, ch3 has no interrupt enable
    v_en = 4'b1001; v_rel = 1; v_drain = 4'b1001;
    load(0, 'h300, 2);
    load(3, 'h4FE, 2);
    req_rises = 0;
    run(60);
    chk(req_rises == 2, "R7 bus re-requested per channel", req_rises, 2);
    chk(dut_w[0] == 2 && dut_w[3] == 2, "R8 per-channel totals", dut_w[0] + dut_w[3], 4);
    chk(irq[3] == 0, "R9 masked interrupt", irq[3], 0);
    chk(irq[0] == 1, "R9 enabled interrupt", irq[0], 1);

    // D: disabled channel does not request
    v_en = 4'b0000; v_rel = 0;
    load(0, 'h600, 3);
    req_rises = 0;
    run(20);
    chk(req_rises == 0 && dut_w[0] == 2, "R2 disabled channel idle", req_rises, 0);
    v_en = 4'b0001;
    run(30);
    chk(dut_w[0] == 5, "R2 enabled channel served", dut_w[0], 5);

    // E: higher priority arrives during a burst
    v_en = 4'b1001; v_drain = 4'b1001;
    load(3, 'h700, 9);
    run(8);
    load(0, 'h800, 3);
    run(120);
    chk(dut_w[3] == 11, "R5 ch3 full transfer", dut_w[3], 11);
    chk(dut_w[0] == 8, "R5 ch0 served after", dut_w[0], 8);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule